// File: doc/BRIEF.md
# Command-Driven Power Mode Controller

This block tracks the power state of a receiver front end. It sits behind the serial command decoder. For every decoded command it receives a one-cycle pulse, along with a flag that tells whether that command asks for sleep. A carrier-detect input from the front end tells the block whether a signal is being received. The block reports one of three modes: sleep, standby or operating. It also drives one enable line that turns off every circuit not needed to keep register contents and the serial port working.

A sleep command puts the block to sleep from any mode. While asleep, the carrier input has no effect. Only two things bring the block out of sleep: a synchronous power-on reset, or any decoded command that is not the sleep command. While awake, the carrier input picks the mode, standby or operating, after it has passed through a two-flop synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstPor` is high at a rising clock edge, the next `modeOut` is standby (2'b01), `pwrDownEn` is 0, and both synchronizer stages are cleared.
- R2: A command pulse with `cmdIsSleep`=1 makes `modeOut` sleep (2'b00) after the next edge. This holds from standby and from operating.
- R3: A sleep command received while already asleep keeps `modeOut` at sleep.
- R4: A command pulse with `cmdIsSleep`=0 received while asleep leaves sleep after the next edge. The new mode is standby or operating, chosen by the synchronized carrier.
- R5: While asleep and with no command pulse, `modeOut` stays at sleep whatever `carrierIn` does.
- R6: While awake with the synchronized carrier low, `modeOut` is standby (2'b01).
- R7: While awake with the synchronized carrier high, `modeOut` is operating (2'b10). A change on `carrierIn` shows on `modeOut` after the third rising edge, counting two synchronizer stages and the mode register.
- R8: `pwrDownEn` is 1 exactly when `modeOut` is sleep.
- R9: `modeOut` never shows the code 2'b11.
- R10: `rstPor` takes priority over a command pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPor | input | 1 | Synchronous power-on reset, active high |
| cmdValid | input | 1 | One-cycle pulse per decoded serial command |
| cmdIsSleep | input | 1 | Marks the pulsed command as the sleep command |
| carrierIn | input | 1 | Asynchronous carrier-present indication |
| modeOut | output | 2 | Mode code: 00 sleep, 01 standby, 10 operating |
| pwrDownEn | output | 1 | High to power down nonessential circuits |

## Verification
Both outputs are registered, so a wrong sleep/awake state in the control shows on `modeOut` and `pwrDownEn` one edge after the command that caused it. A missed wake, or a stuck sleep, persists until the next command, so the bench follows each wake with idle cycles. A synchronizer of the wrong depth moves the standby-to-operating change away from the third edge after the carrier changes, so the bench checks every cycle around that step. A carrier leaking into sleep would show as an operating code during quiet sleep cycles, so the bench toggles the carrier during those cycles.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_STBY  = 2'b01,
    MODE_OPER  = 2'b10
  } modeT;

  // Strobes from the control FSM to the mode datapath
  typedef struct packed {
    logic clearAll;    // power-on reset in progress
    logic forceSleep;  // sleep command accepted this cycle
    logic holdSleep;   // already asleep, nothing to wake on
  } ctrlStrobesT;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstPor,
  input  logic        cmdValid,
  input  logic        cmdIsSleep,
  output ctrlStrobesT ctrl
);

  typedef enum logic {ST_AWAKE = 1'b0, ST_ASLEEP = 1'b1} stateT;

  stateT stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    if (rstPor)        stateNext = ST_AWAKE;
    else if (cmdValid) stateNext = cmdIsSleep ? ST_ASLEEP : ST_AWAKE;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateNext;
  end

  always_comb begin
    ctrl.clearAll   = rstPor;
    ctrl.forceSleep = !rstPor && cmdValid && cmdIsSleep;
    ctrl.holdSleep  = !rstPor && !cmdValid && (stateQ == ST_ASLEEP);
  end

endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  ctrlStrobesT ctrl,
  input  logic        carrierIn,
  output logic [1:0]  modeOut,
  output logic        pwrDownEn
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   carrierSync;
  modeT                   modeQ, modeNext;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (ctrl.clearAll) syncQ[g] <= 1'b0;
        else if (g == 0)   syncQ[g] <= carrierIn;
        else               syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign carrierSync = syncQ[LAST_STAGE];

  always_comb begin
    if (ctrl.clearAll)                            modeNext = MODE_STBY;
    else if (ctrl.forceSleep || ctrl.holdSleep)   modeNext = MODE_SLEEP;
    else if (carrierSync)                         modeNext = MODE_OPER;
    else                                          modeNext = MODE_STBY;
  end

  always_ff @(posedge clk) begin
    modeQ     <= modeNext;
    pwrDownEn <= (modeNext == MODE_SLEEP);
  end

  assign modeOut = modeQ;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstPor,
  input  logic       cmdValid,
  input  logic       cmdIsSleep,
  input  logic       carrierIn,
  output logic [1:0] modeOut,
  output logic       pwrDownEn
);

  ctrlStrobesT ctrl;

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rstPor     (rstPor),
    .cmdValid   (cmdValid),
    .cmdIsSleep (cmdIsSleep),
    .ctrl       (ctrl)
  );

  pwr_mode_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .ctrl      (ctrl),
    .carrierIn (carrierIn),
    .modeOut   (modeOut),
    .pwrDownEn (pwrDownEn)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rstPor,
  input logic       cmdValid,
  input logic       cmdIsSleep,
  input logic [1:0] modeOut,
  input logic       pwrDownEn
);

  AST_RESET_STBY: assert property (@(posedge clk)
    rstPor |=> (modeOut == 2'b01 && !pwrDownEn)); // R1

  AST_RESET_BEATS_CMD: assert property (@(posedge clk)
    (rstPor && cmdValid && cmdIsSleep) |=> (modeOut == 2'b01)); // R10

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rstPor)
    (cmdValid && cmdIsSleep) |=> (modeOut == 2'b00)); // R2

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rstPor)
    (modeOut == 2'b00 && !cmdValid) |=> (modeOut == 2'b00)); // R5

  AST_WAKE_ON_CMD: assert property (@(posedge clk) disable iff (rstPor)
    (cmdValid && !cmdIsSleep) |=> (modeOut != 2'b00)); // R4

  AST_PWRDOWN_MATCH: assert property (@(posedge clk) disable iff (rstPor)
    $past(!rstPor) |-> (pwrDownEn == (modeOut == 2'b00))); // R8

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rstPor)
    $past(!rstPor) |-> (modeOut != 2'b11)); // R9

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rstPor     (rstPor),
  .cmdValid   (cmdValid),
  .cmdIsSleep (cmdIsSleep),
  .modeOut    (modeOut),
  .pwrDownEn  (pwrDownEn)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstPor = 1'b1;
  logic       cmdValid = 1'b0;
  logic       cmdIsSleep = 1'b0;
  logic       carrierIn = 1'b0;
  logic [1:0] modeOut;
  logic       pwrDownEn;

  always #5 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk        (clk),
    .rstPor     (rstPor),
    .cmdValid   (cmdValid),
    .cmdIsSleep (cmdIsSleep),
    .carrierIn  (carrierIn),
    .modeOut    (modeOut),
    .pwrDownEn  (pwrDownEn)
  );

  typedef struct {
    logic [1:0] mode;
    string      tag;
  } expT;

  expT  expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Model built from the requirements: two-stage carrier delay, sleep flag
  logic       mStage1 = 1'b0;
  logic       mStage2 = 1'b0;
  logic [1:0] mMode   = 2'b01;

  task automatic step(input logic r, input logic cv, input logic cs,
                      input logic car, input string tag);
    logic [1:0] nm;
    @(negedge clk);
    rstPor = r; cmdValid = cv; cmdIsSleep = cs; carrierIn = car;
    if (r)                           nm = 2'b01;  // R1 / R10
    else if (cv && cs)               nm = 2'b00;  // R2 / R3
    else if (mMode == 2'b00 && !cv)  nm = 2'b00;  // R5
    else                             nm = mStage2 ? 2'b10 : 2'b01; // R4 R6 R7
    mStage2 = r ? 1'b0 : mStage1;
    mStage1 = r ? 1'b0 : car;
    mMode   = nm;
    expQ.push_back('{mode: nm, tag: tag});
  endtask

  // Monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (modeOut !== e.mode) begin
          errors++;
          $display("FAIL %s mode actual=%b expected=%b", e.tag, modeOut, e.mode);
        end
        checks++;
        if (pwrDownEn !== (e.mode == 2'b00)) begin
          errors++;
          $display("FAIL R8 pwrDownEn actual=%b expected=%b", pwrDownEn, (e.mode == 2'b00));
        end
        checks++;
        if (modeOut === 2'b11) begin
          errors++;
          $display("FAIL R9 mode actual=%b expected=not 11", modeOut);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R10: reset with a sleep command pending, carrier high
    step(1, 1, 1, 1, "R10");
    step(1, 0, 0, 1, "R1");
    step(1, 0, 0, 0, "R1");
    // R6: awake, no carrier
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R6");
    // R7: carrier rises, operating on third edge
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    // R2: sleep from operating
    step(0, 1, 1, 1, "R2");
    // R5: idle sleep, carrier toggling
    for (int i = 0; i < 6; i++) step(0, 0, 0, i[0], "R5");
    // R3: sleep while asleep
    step(0, 1, 1, 1, "R3");
    step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, "R5");
    // R4: wake with carrier settled high -> operating
    step(0, 1, 0, 1, "R4");
    step(0, 0, 0, 1, "R7");
    // carrier falls -> standby after three edges
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R6");
    // R2: sleep from standby, then wake with carrier low
    step(0, 1, 1, 0, "R2");
    step(0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, "R6");
    // R1: reset while asleep
    step(0, 1, 1, 0, "R2");
    step(1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R6");
    // R1: synchronizer cleared by reset: carrier high just before reset
    step(0, 0, 0, 1, "R7");
    step(1, 0, 0, 1, "R1");
    step(0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, "R7");
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule